// File: doc/BRIEF.md
# Receive Datapath Reset Release Sequencer

This block keeps the digital part of a serial receiver in reset until the clock-recovery loop has been locked to the incoming data for an unbroken minimum time. The data-lock indication from the recovery loop may chatter before real traffic arrives. Any low sample therefore throws away the time collected so far, and the count starts again from zero. There is no timeout: the block waits for as long as it takes. How long lock takes depends on the edge density of the line data and on the frequency offset between the two ends.

The lock-status inputs and the lock-mode controls come from another clock domain. All of them pass through a synchroniser before use. The hold time is given in nanoseconds. The block turns it into a cycle count from the clock frequency parameter, rounding up. The locked-to-reference status has no meaning once the loop tracks data, so it is synchronised but never used to make a decision. If data lock is lost after release, reset is applied again and the whole wait starts over.

Top module: `rx_pcs_rst_seq`

## Requirements
- R1: While `rst` is high at a rising edge, `rx_dig_rst_o` is 1 and `rx_ready_o` is 0 after that edge.
- R2: The hold count is HOLD_CYC = ceil(HOLD_NS × CLK_HZ / 10^9). The defaults (4000 ns, 100 MHz) give 400 cycles.
- R3: Call the first edge at which a qualifying lock sample is taken edge 0. If every later sample also qualifies, `rx_dig_rst_o` falls at edge HOLD_CYC+2. Release needs HOLD_CYC+1 consecutive qualifying samples.
- R4: A single non-qualifying sample restarts the count. If a run has only HOLD_CYC qualifying samples before a non-qualifying one, no release happens.
- R5: `lock_ref_i` has no effect on either output, whatever its pattern.
- R6: There is no timeout. With no qualifying samples, `rx_dig_rst_o` stays 1 for any length of time, and a later valid run still releases it as in R3.
- R7: If a non-qualifying sample is taken at edge e while released, `rx_dig_rst_o` is 1 again after edge e+2. A new full run is then needed before the next release.
- R8: A sample qualifies when `lock_data_i` is 1 and the mode is not "forced to reference". The mode is forced to reference when `force_ref_i`=1 and `force_data_i`=0. When `force_data_i`=1, the value of `force_ref_i` does not matter.
- R9: `rx_ready_o` is always the inverse of `rx_dig_rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_data_i | input | 1 | Recovery loop locked-to-data status (asynchronous) |
| lock_ref_i | input | 1 | Recovery loop locked-to-reference status (asynchronous, ignored) |
| force_ref_i | input | 1 | Lock-mode control: force lock to reference |
| force_data_i | input | 1 | Lock-mode control: force lock to data (overrides force_ref_i) |
| rx_dig_rst_o | output | 1 | Active-high digital reset for the receive datapath |
| rx_ready_o | output | 1 | High once the datapath reset has been released |

## Verification
The assertions assume that `rst` is high at the first clock edge. Apart from that they place no timing limit on the status or mode inputs, because these are synchronised inside the block. The bench changes all inputs on the falling edge, holds reset for several cycles at the start, and toggles `lock_ref_i` randomly on every cycle. Random lock runs are drawn both close to the hold count and far from it, so the exact-boundary cases come up often.

// File: rtl/rxrs_pkg.sv
package rxrs_pkg;

  localparam longint unsigned NS_PER_S = 64'd1_000_000_000;

  // Cycles needed to cover a time span, rounded up
  function automatic longint unsigned span_to_cycles(input longint unsigned clk_hz,
                                                     input longint unsigned span_ns);
    return (clk_hz * span_ns + NS_PER_S - 64'd1) / NS_PER_S;
  endfunction

  // Bit positions inside the synchronised status vector
  localparam int unsigned ST_LOCK_DATA = 0;
  localparam int unsigned ST_LOCK_REF  = 1;
  localparam int unsigned ST_FRC_REF   = 2;
  localparam int unsigned ST_FRC_DATA  = 3;
  localparam int unsigned ST_WIDTH     = 4;

endpackage

// File: rtl/rxrs_sync.sv
module rxrs_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];

endmodule

// File: rtl/rxrs_hold_timer.sv
module rxrs_hold_timer #(
  parameter int unsigned HOLD_CYC = 400,
  parameter int unsigned CNT_W    = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic qual_i,
  output logic done_o
);

  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(HOLD_CYC);

  logic [CNT_W-1:0] cnt;

  // Counts unbroken qualifying cycles, sticks at the limit
  always_ff @(posedge clk) begin
    if (rst || !qual_i)   cnt <= '0;
    else if (cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign done_o = (cnt == LIMIT);

  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT);

  p_done_after_run_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(qual_i));

endmodule

// File: rtl/rxrs_rel_ctrl.sv
module rxrs_rel_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic qual_i,
  input  logic done_i,
  output logic dig_rst_o,
  output logic ready_o
);

  logic release_ok;
  assign release_ok = qual_i && done_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      dig_rst_o <= 1'b1;
      ready_o   <= 1'b0;
    end else begin
      dig_rst_o <= !release_ok;
      ready_o   <= release_ok;
    end
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (dig_rst_o && !ready_o));

  p_drop_reassert_r7: assert property (@(posedge clk) disable iff (rst)
    (!dig_rst_o && !qual_i) |=> dig_rst_o);

  p_release_after_hold_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(dig_rst_o) |-> $past(done_i));

  p_ready_inverse_r9: assert property (@(posedge clk) disable iff (rst)
    dig_rst_o != ready_o);

endmodule

// File: rtl/rx_pcs_rst_seq.sv
module rx_pcs_rst_seq #(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned HOLD_NS     = 4000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic lock_data_i,
  input  logic lock_ref_i,
  input  logic force_ref_i,
  input  logic force_data_i,
  output logic rx_dig_rst_o,
  output logic rx_ready_o
);

  import rxrs_pkg::*;

  localparam int unsigned HOLD_RAW = int'(span_to_cycles(64'(CLK_HZ), 64'(HOLD_NS)));
  localparam int unsigned HOLD_CYC = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
  localparam int unsigned CNT_W    = $clog2(HOLD_CYC + 1);

  logic [ST_WIDTH-1:0] st_raw;
  logic [ST_WIDTH-1:0] st_s;
  logic                qual;
  logic                done;

  assign st_raw[ST_LOCK_DATA] = lock_data_i;
  assign st_raw[ST_LOCK_REF]  = lock_ref_i;
  assign st_raw[ST_FRC_REF]   = force_ref_i;
  assign st_raw[ST_FRC_DATA]  = force_data_i;

  rxrs_sync #(.WIDTH(ST_WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (st_raw),
    .q_o (st_s)
  );

  // Forced-to-reference mode means data lock carries no meaning
  logic held_on_ref;
  assign held_on_ref = st_s[ST_FRC_REF] && !st_s[ST_FRC_DATA];
  assign qual        = st_s[ST_LOCK_DATA] && !held_on_ref;

  rxrs_hold_timer #(.HOLD_CYC(HOLD_CYC), .CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .qual_i (qual),
    .done_o (done)
  );

  rxrs_rel_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .qual_i    (qual),
    .done_i    (done),
    .dig_rst_o (rx_dig_rst_o),
    .ready_o   (rx_ready_o)
  );

  // Reference-lock chatter must not disturb a released datapath
  p_ref_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (!rx_dig_rst_o && qual && (st_s[ST_LOCK_REF] != $past(st_s[ST_LOCK_REF])))
      |=> !rx_dig_rst_o);

  p_mode_ref_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (st_s[ST_FRC_REF] && !st_s[ST_FRC_DATA]) |=> rx_dig_rst_o);

endmodule

// File: tb/sim_rx_pcs_rst_seq.sv
module sim_rx_pcs_rst_seq;

  localparam int HOLD = 400;   // R2: ceil(4000 ns * 100 MHz) = 400

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lock_data = 1'b0, lock_ref = 1'b0, frc_ref = 1'b0, frc_data = 1'b0;
  logic dig_rst, ready;

  int total = 0, bad = 0, cycles = 0;
  bit started = 0, finished = 0;
  string tag = "R1";

  // Bench model: length of the current run of qualifying samples
  int run = 0, h1 = 0, h2 = 0;
  bit exp_rst = 1'b1;

  always #5 clk = ~clk;

  rx_pcs_rst_seq u0 (
    .clk (clk), .rst (rst), .lock_data_i (lock_data), .lock_ref_i (lock_ref),
    .force_ref_i (frc_ref), .force_data_i (frc_data),
    .rx_dig_rst_o (dig_rst), .rx_ready_o (ready)
  );

  function automatic bit qualifies(bit l, bit fr, bit fd);
    return l && !(fr && !fd);   // R8
  endfunction

  function automatic bit expect_reset(bit in_rst, int run_two_back);
    return in_rst ? 1'b1 : (run_two_back < HOLD + 1);   // R1, R3, R4
  endfunction

  always @(posedge clk) begin
    int r;
    exp_rst = expect_reset(rst, h2);
    if (rst) r = 0;
    else if (qualifies(lock_data, frc_ref, frc_data)) r = (run > HOLD) ? HOLD + 1 : run + 1;
    else r = 0;
    run = r;
    h2 = h1;
    h1 = r;
    started = 1;
    cycles++;
  end

  always @(negedge clk) begin
    if (started && !finished) begin
      total++;
      if (dig_rst !== exp_rst) begin
        bad++;
        $display("FAIL %s rx_dig_rst_o actual=%b expected=%b at cycle %0d", tag, dig_rst, exp_rst, cycles);
      end
      total++;
      if (ready !== !exp_rst) begin
        bad++;
        $display("FAIL R9 rx_ready_o actual=%b expected=%b at cycle %0d", ready, !exp_rst, cycles);
      end
    end
  end

  task automatic drive(input bit l, input bit fr, input bit fd, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      lock_data = l; frc_ref = fr; frc_data = fd;
      lock_ref = 1'($urandom % 2);   // R5: random reference-lock chatter
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    while (cycles < 200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    tag = "R1";
    drive(1, 0, 0, 6);
    @(negedge clk) rst = 1'b0;
    tag = "R6,R5";               // no lock for a long time: stays in reset
    drive(0, 0, 0, 1500);
    tag = "R4";                  // exactly HOLD samples: no release
    drive(1, 0, 0, HOLD);
    drive(0, 0, 0, 10);
    tag = "R2,R3,R7";            // HOLD+1 samples: one release cycle, then drop
    drive(1, 0, 0, HOLD + 1);
    drive(0, 0, 0, 10);
    tag = "R4";                  // one-cycle glitch mid-window
    drive(1, 0, 0, 300);
    drive(0, 0, 0, 1);
    drive(1, 0, 0, 600);
    tag = "R7";
    drive(0, 0, 0, 5);
    tag = "R8";                  // forced to reference, then forced to data
    drive(1, 1, 0, 700);
    drive(1, 1, 1, 700);
    drive(1, 0, 1, 300);
    tag = "R5";                  // released, reference status chattering
    drive(1, 0, 0, 500);
    tag = "R1";                  // reset while released
    @(negedge clk) rst = 1'b1;
    drive(1, 0, 0, 4);
    @(negedge clk) rst = 1'b0;
    drive(1, 0, 0, HOLD + 10);
    tag = "R4";                  // random runs around the boundary
    for (int p = 0; p < 40; p++) begin
      int m = $urandom % 8;
      bit fr = (m == 0) || (m == 1);
      bit fd = (m == 1) || (m == 2);
      int hi = ($urandom % 2) ? (HOLD - 5 + int'($urandom % 12)) : (1 + int'($urandom % (3 * HOLD)));
      drive(1, fr, fd, hi);
      drive(0, fr, fd, 1 + int'($urandom % 15));
    end
    drive(0, 0, 0, 4);
    finish_run();
  end

endmodule